// File: doc/BRIEF.md
# Flash Bank Swap Controller

This block sits between a flash access requester and a flash array built from two banks of equal size. For every access it translates a logical address into a physical one. In normal operation the physical address equals the logical address. When a swap is in effect, the most significant address bit, which selects the bank, is inverted. The upper bank then answers at logical address zero, and the lower bank moves up. Software can use this to boot from either bank, for example after an image update.

Two write-only registers control the swap, and each is guarded by its own key byte.

- **Swap register.** Selects whether the banks are exchanged.
- **Policy register.** Can forbid swapping for good; only a reset allows it again.

A read-only status word reports whether a swap is in effect and whether swapping is still allowed. A write whose key is wrong changes nothing and raises a one-cycle error pulse.

An access starts on a request while the block is idle. The block captures the translated address at that point and holds it for a fixed number of cycles. A change of the swap state therefore never disturbs an access already in progress.

Top module: `flash_bank_swap`

## Requirements
- R1: After reset the status word reads 0x0000_0400: swapping is allowed (bit 10 = 1) and no swap is active (bit 12 = 0). `key_err` and `acc_busy` are 0.
- R2: A write to the policy slot (`reg_sel` = 0) counts only when `reg_wdata[31:24]` = 0xCA. With that key and `reg_wdata[0]` = 1, status bit 10 reads 0 from the next cycle on.
- R3: Once swapping has been forbidden, it stays forbidden until reset. A keyed policy write with bit 0 = 0 does not allow it again.
- R4: A write to the swap slot (`reg_sel` = 1) counts only when `reg_wdata[31:24]` = 0x58 and swapping is allowed. Bit 0 = 1 sets the swap, and status bit 12 reads 1 from the next cycle. Bit 0 = 0 restores the normal map, and bit 12 reads 0.
- R5: While swapping is forbidden, a swap-slot write with the correct key is ignored. The current swap state is kept and no key error is raised.
- R6: A policy-slot or swap-slot write with any other key byte changes no state. It raises `key_err` for exactly one cycle, the cycle after the write.
- R7: The physical address equals the logical address when no swap is active. When a swap is active, it equals the logical address with the top bit (bit `ADDR_W-1`, bit 21 by default) inverted and every other bit unchanged.
- R8: The mapping is sampled when an access is accepted (`acc_req` while `acc_busy` = 0). An access accepted in the same cycle as a swap write uses the old mapping, and the following access uses the new one. `acc_busy` stays high for exactly `ACC_CYC` cycles, and `acc_paddr` stays constant throughout.
- R9: Reads of the policy slot, the swap slot and the unused slot (`reg_sel` = 3) return zero. All status bits other than 12 and 10 read zero.
- R10: Writes to the status slot (`reg_sel` = 2) or the unused slot change no state and raise no key error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot: 0 policy, 1 swap, 2 status, 3 unused |
| reg_wdata | input | 32 | Write data; key byte in bits 31:24, control bit in bit 0 |
| reg_rdata | output | 32 | Read data of the selected slot (combinational) |
| key_err | output | 1 | One-cycle pulse after a write with a wrong key |
| acc_req | input | 1 | Access request, accepted while not busy |
| acc_laddr | input | ADDR_W | Logical flash address |
| acc_busy | output | 1 | High while an access is in progress |
| acc_paddr | output | ADDR_W | Physical flash address of the current access |

## Verification
The bench builds the block with `ADDR_W` = 16 and `ACC_CYC` = 3. With these values the bank bit is bit 15, so addresses can be written in short hex form, and every access lasts only three cycles. This keeps the same-cycle case of R8 quick to reach: a swap write and an access request arrive together, and the access must complete on the old mapping. The short access length also lets the bench check the busy length and the held address on every access. The run covers the following:

- each bank bit value, with the swap on and with it off;
- wrong keys on both keyed slots;
- the permanent lock of the policy;
- a reset that lifts the lock.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    // Key byte position inside a register write word
    localparam int KEY_HI = 31;
    localparam int KEY_LO = 24;

    localparam logic [7:0] POLICY_KEY = 8'hCA;
    localparam logic [7:0] SWAP_KEY   = 8'h58;

    // Status word bit positions
    localparam int ST_SWAPPED_BIT = 12;
    localparam int ST_ALLOW_BIT   = 10;

    typedef enum logic [1:0] {
        SEL_POLICY = 2'd0,
        SEL_SWAP   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic allow;
        logic swapped;
        logic key_err;
    } ctl_state_t;

endpackage

// File: rtl/fbs_key_gate.sv
module fbs_key_gate #(
    parameter logic [7:0] KEY_VAL = 8'h00
) (
    input  logic       wr,
    input  logic       slot_hit,
    input  logic [7:0] key_byte,
    output logic       wr_ok,
    output logic       wr_bad
);

    logic key_match;

    always_comb begin
        key_match = (key_byte == KEY_VAL);
        wr_ok     = wr && slot_hit && key_match;
        wr_bad    = wr && slot_hit && !key_match;
    end

endmodule

// File: rtl/fbs_swap_ctl.sv
module fbs_swap_ctl
    import fbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pol_ok,
    input  logic pol_bad,
    input  logic pol_bit,
    input  logic swp_ok,
    input  logic swp_bad,
    input  logic swp_bit,
    output logic allow,
    output logic swapped,
    output logic key_err
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.key_err = pol_bad || swp_bad;
        // policy can only be tightened; clearing bit 0 never re-opens it
        if (pol_ok && pol_bit) begin
            st_d.allow = 1'b0;
        end
        if (swp_ok && st_q.allow) begin
            st_d.swapped = swp_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{allow: 1'b1, swapped: 1'b0, key_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign allow   = st_q.allow;
    assign swapped = st_q.swapped;
    assign key_err = st_q.key_err;

endmodule

// File: rtl/fbs_remap.sv
module fbs_remap #(
    parameter int ADDR_W  = 22,
    parameter int ACC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_laddr,
    input  logic              swapped,
    output logic              acc_busy,
    output logic [ADDR_W-1:0] acc_paddr
);

    localparam int BANK_BIT = ADDR_W - 1;
    localparam int CNT_W    = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] paddr;
    } acc_state_t;

    acc_state_t        as_d, as_q;
    logic [ADDR_W-1:0] mapped;

    // bank-select bit flips with the swap; all lower bits pass through
    generate
        if (ADDR_W > 1) begin : g_split
            assign mapped = {acc_laddr[BANK_BIT] ^ swapped, acc_laddr[BANK_BIT-1:0]};
        end else begin : g_single
            assign mapped = acc_laddr ^ swapped;
        end
    endgenerate

    always_comb begin
        as_d = as_q;
        if (as_q.busy) begin
            if (as_q.cnt == '0) begin
                as_d.busy = 1'b0;
            end else begin
                as_d.cnt = as_q.cnt - 1'b1;
            end
        end else if (acc_req) begin
            as_d.busy  = 1'b1;
            as_d.cnt   = CNT_LOAD;
            as_d.paddr = mapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q <= '0;
        end else begin
            as_q <= as_d;
        end
    end

    assign acc_busy  = as_q.busy;
    assign acc_paddr = as_q.paddr;

endmodule

// File: rtl/flash_bank_swap.sv
module flash_bank_swap
    import fbs_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int ACC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              key_err,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_laddr,
    output logic              acc_busy,
    output logic [ADDR_W-1:0] acc_paddr
);

    reg_sel_e sel;
    logic     pol_ok, pol_bad, swp_ok, swp_bad;
    logic     allow, swapped;

    assign sel = reg_sel_e'(reg_sel);

    fbs_key_gate #(.KEY_VAL(POLICY_KEY)) u_pol_gate (
        .wr       (reg_wr),
        .slot_hit (sel == SEL_POLICY),
        .key_byte (reg_wdata[KEY_HI:KEY_LO]),
        .wr_ok    (pol_ok),
        .wr_bad   (pol_bad)
    );

    fbs_key_gate #(.KEY_VAL(SWAP_KEY)) u_swp_gate (
        .wr       (reg_wr),
        .slot_hit (sel == SEL_SWAP),
        .key_byte (reg_wdata[KEY_HI:KEY_LO]),
        .wr_ok    (swp_ok),
        .wr_bad   (swp_bad)
    );

    fbs_swap_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pol_ok  (pol_ok),
        .pol_bad (pol_bad),
        .pol_bit (reg_wdata[0]),
        .swp_ok  (swp_ok),
        .swp_bad (swp_bad),
        .swp_bit (reg_wdata[0]),
        .allow   (allow),
        .swapped (swapped),
        .key_err (key_err)
    );

    fbs_remap #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC)) u_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_laddr (acc_laddr),
        .swapped   (swapped),
        .acc_busy  (acc_busy),
        .acc_paddr (acc_paddr)
    );

    // keyed slots are write-only and read back as zero
    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_STATUS) begin
            reg_rdata[ST_SWAPPED_BIT] = swapped;
            reg_rdata[ST_ALLOW_BIT]   = allow;
        end
    end

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker
    import fbs_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              key_err,
    input logic [ADDR_W-1:0] acc_laddr,
    input logic              acc_busy,
    input logic [ADDR_W-1:0] acc_paddr,
    input logic              swapped,
    input logic              allow
);

    logic       wrong_key_wr;
    logic       swap_key_wr;
    logic [7:0] kb;

    assign kb           = reg_wdata[KEY_HI:KEY_LO];
    assign wrong_key_wr = reg_wr && (((reg_sel == 2'd0) && (kb != POLICY_KEY)) ||
                                     ((reg_sel == 2'd1) && (kb != SWAP_KEY)));
    assign swap_key_wr  = reg_wr && (reg_sel == 2'd1) && (kb == SWAP_KEY);

    AST_KEYERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |-> $past(wrong_key_wr)); // R6

    AST_BADKEY_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |-> ($stable(swapped) && $stable(allow))); // R6

    AST_POLICY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> !allow); // R3

    AST_SWAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> $stable(swapped)); // R5

    AST_SWAP_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swapped) |-> $past(swap_key_wr && allow)); // R4

    AST_PADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && $past(acc_busy)) |-> $stable(acc_paddr)); // R8

    AST_MAP_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_busy) |->
            (acc_paddr == ($past(acc_laddr) ^ {$past(swapped), {(ADDR_W-1){1'b0}}}))); // R7

endmodule

bind flash_bank_swap fbs_checker #(.ADDR_W(ADDR_W)) u_fbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .key_err   (key_err),
    .acc_laddr (acc_laddr),
    .acc_busy  (acc_busy),
    .acc_paddr (acc_paddr),
    .swapped   (swapped),
    .allow     (allow)
);

// File: tb/tb_flash_bank_swap.sv
`timescale 1ns/1ps
module tb_flash_bank_swap;

    localparam int AW   = 16;
    localparam int NCYC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd2;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          key_err;
    logic          acc_req = 1'b0;
    logic [AW-1:0] acc_laddr = '0;
    logic          acc_busy;
    logic [AW-1:0] acc_paddr;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    flash_bank_swap #(.ADDR_W(AW), .ACC_CYC(NCYC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .key_err   (key_err),
        .acc_req   (acc_req),
        .acc_laddr (acc_laddr),
        .acc_busy  (acc_busy),
        .acc_paddr (acc_paddr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input bit sw, input bit al);
        return (32'(sw) << 12) | (32'(al) << 10);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_status(input logic [31:0] exp, input string req);
        reg_sel = 2'd2;
        @(negedge clk);
        check(reg_rdata === exp, req, "status", reg_rdata, exp);
    endtask

    task automatic check_read_zero(input logic [1:0] sel, input string req);
        reg_sel = sel;
        @(negedge clk);
        check(reg_rdata === 32'h0, req, "slot read", reg_rdata, 32'h0);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data,
                             input bit exp_err, input string req);
        step();
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = data;
        step();
        reg_wr = 1'b0;
        reg_wdata = '0;
        @(negedge clk);
        check(key_err === exp_err, req, "key_err after write", 32'(key_err), 32'(exp_err));
        @(negedge clk);
        check(key_err === 1'b0, req, "key_err pulse end", 32'(key_err), 32'h0);
    endtask

    task automatic wait_idle();
        while (acc_busy) step();
    endtask

    task automatic access(input logic [AW-1:0] la, input logic [AW-1:0] exp,
                          input string req);
        wait_idle();
        step();
        acc_req = 1'b1;
        acc_laddr = la;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        step();
        acc_req = 1'b0;
        wait_idle();
    endtask

    // Monitor: pops expected physical addresses as accesses start
    initial begin
        bit            in_acc = 1'b0;
        int            len = 0;
        logic [AW-1:0] held = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                in_acc = 1'b0;
            end else if (acc_busy) begin
                if (!in_acc) begin
                    in_acc = 1'b1;
                    len = 1;
                    held = acc_paddr;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected access", 32'(acc_paddr), 32'h0);
                    end else begin
                        logic [AW-1:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(acc_paddr === e, t, "physical address", 32'(acc_paddr), 32'(e));
                    end
                end else begin
                    len++;
                    check(acc_paddr === held, "R8", "address held", 32'(acc_paddr), 32'(held));
                end
            end else if (in_acc) begin
                in_acc = 1'b0;
                check(len == NCYC, "R8", "busy length", 32'(len), 32'(NCYC));
            end
        end
    end

    // Watchdog
    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(key_err === 1'b0, "R1", "key_err", 32'(key_err), 32'h0);
        check(acc_busy === 1'b0, "R1", "acc_busy", 32'(acc_busy), 32'h0);
        check_status(st(0, 1), "R1");
        // R9: write-only slots read zero
        check_read_zero(2'd0, "R9");
        check_read_zero(2'd1, "R9");
        check_read_zero(2'd3, "R9");

        // R7: normal map in both banks
        access(16'h1234, 16'h1234, "R7");
        access(16'h9234, 16'h9234, "R7");

        // R6: wrong keys
        reg_write(2'd1, 32'h5700_0001, 1'b1, "R6");
        check_status(st(0, 1), "R6");
        reg_write(2'd0, 32'hCB00_0001, 1'b1, "R6");
        check_status(st(0, 1), "R6");

        // R4: keyed swap on
        reg_write(2'd1, 32'h5800_0001, 1'b0, "R4");
        check_status(st(1, 1), "R4");

        // R7: swapped map
        access(16'h1234, 16'h9234, "R7");
        access(16'h9ABC, 16'h1ABC, "R7");

        // R10: status and unused slots ignore writes
        reg_write(2'd2, 32'hFFFF_FFFF, 1'b0, "R10");
        reg_write(2'd3, 32'h5800_0000, 1'b0, "R10");
        check_status(st(1, 1), "R10");

        // R8: access accepted with a swap write uses old map
        wait_idle();
        step();
        reg_wr = 1'b1;
        reg_sel = 2'd1;
        reg_wdata = 32'h5800_0000;
        acc_req = 1'b1;
        acc_laddr = 16'h0100;
        exp_q.push_back(16'h8100);
        tag_q.push_back("R8");
        step();
        reg_wr = 1'b0;
        reg_wdata = '0;
        acc_req = 1'b0;
        wait_idle();
        access(16'h0100, 16'h0100, "R8");
        check_status(st(0, 1), "R4");

        reg_write(2'd1, 32'h5800_0001, 1'b0, "R4");
        check_status(st(1, 1), "R4");
        check_read_zero(2'd0, "R9");
        check_read_zero(2'd1, "R9");

        // R2: policy forbids swapping
        reg_write(2'd0, 32'hCA00_0001, 1'b0, "R2");
        check_status(st(1, 0), "R2");

        // R5: swap writes ignored while forbidden
        reg_write(2'd1, 32'h5800_0000, 1'b0, "R5");
        check_status(st(1, 0), "R5");
        access(16'h0042, 16'h8042, "R5");

        // R3: policy cannot be reopened
        reg_write(2'd0, 32'hCA00_0000, 1'b0, "R3");
        check_status(st(1, 0), "R3");

        // R3 / R1: reset lifts the lock
        wait_idle();
        step();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        check_status(st(0, 1), "R3");
        reg_write(2'd1, 32'h5800_0001, 1'b0, "R3");
        check_status(st(1, 1), "R3");

        repeat (4) step();
        check(exp_q.size() == 0, "R8", "pending accesses", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule